// File: doc/BRIEF.md
# Framed 3-Bit Symbol Detector

This block watches a serial bit stream that is cut into fixed three-bit symbols, one bit per clock. The symbols follow each other with no gap and never overlap. The first bit after reset is the first bit of a symbol. The block flags each symbol whose middle bit is 1 and whose final bit is 0. Those are the symbols received as 010 or 110. The first bit of a symbol does not matter.

The flag is a Mealy output. It rises during the cycle in which the final bit is on the input, so a downstream register can capture it at the edge that consumes that bit. A second output marks every cycle that carries the last bit of a symbol, so neighbouring logic can tell where the symbol boundaries are.

The machine has four states held in two bits: start, after the first bit, last bit pending with a 0 seen, and last bit pending with a 1 seen. Reset is synchronous and active high.

Top module: `frame_sym_detector`

## Requirements
- R1: While `rst` is high, `detect` and `frame_end` are 0. After a clock edge with `rst` high, the next input bit is treated as the first bit of a symbol.
- R2: `frame_end` is 1 exactly in the cycles that present bit positions 3, 6, 9, … counted from the first bit after reset. Bits are numbered 1 to 3 within each symbol.
- R3: `detect` is 1 in a symbol's third-bit cycle when `bit_in` is 0 in that cycle and the second bit of the symbol was 1. This covers the arrival orders 010 and 110.
- R4: The first bit of a symbol has no effect: the codes 0ab and 1ab give the same `detect` value for every a and b.
- R5: `detect` is 0 in every other cycle: on the first and second bits, and on a third bit that is 1 or that follows a second bit of 0.
- R6: Symbols do not overlap. A 1-then-0 pair that straddles a symbol boundary gives no `detect`.
- R7: `detect` follows `bit_in` in the same cycle, with no register between the input and the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset to the start state |
| bit_in | input | 1 | Serial data bit for this cycle |
| detect | output | 1 | High on the last bit of a 010 or 110 symbol |
| frame_end | output | 1 | High when the current bit is the third of its symbol |

## Verification
Both outputs depend only on the state register and the present input bit. Each result is therefore due in the same cycle that holds its bit, and the state moves forward at the following rising edge. The bench drives a new bit just after each falling edge and samples both outputs 2 ns later, well before the edge that consumes the bit. The reference model in the bench then advances its symbol position and its stored previous bit at that edge, so the expected and actual values always refer to the same cycle.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   localparam int FSD_SW = 2;

   // Start state is all zeros so that reset clears the register.
   typedef enum logic [FSD_SW-1:0] {
      ST_START = 2'b00,
      ST_FIRST = 2'b01,
      ST_MIDLO = 2'b10,
      ST_MIDHI = 2'b11
   } fsd_state_t;
endpackage

// File: rtl/fsd_next.sv
module fsd_next
   import fsd_pkg::*;
(
   input  fsd_state_t cur,
   input  logic       bit_in,
   output fsd_state_t nxt
);
   always_comb begin
      unique case (cur)
         ST_START: nxt = ST_FIRST;
         ST_FIRST: nxt = bit_in ? ST_MIDHI : ST_MIDLO;
         default:  nxt = ST_START;
      endcase
   end
endmodule

// File: rtl/fsd_state_reg.sv
module fsd_state_reg
   import fsd_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  fsd_state_t nxt,
   output fsd_state_t cur
);
   always_ff @(posedge clk) begin
      if (rst) cur <= ST_START;
      else     cur <= nxt;
   end
endmodule

// File: rtl/fsd_out.sv
module fsd_out
   import fsd_pkg::*;
#(
   parameter bit GATE_RST = 1'b1
) (
   input  logic       rst,
   input  fsd_state_t cur,
   input  logic       bit_in,
   output logic       detect,
   output logic       frame_end
);
   logic det_raw, end_raw;

   assign end_raw = (cur == ST_MIDLO) || (cur == ST_MIDHI);
   assign det_raw = (cur == ST_MIDHI) && !bit_in;

   generate
      if (GATE_RST) begin : g_gate
         assign detect    = det_raw && !rst;
         assign frame_end = end_raw && !rst;
      end else begin : g_nogate
         assign detect    = det_raw;
         assign frame_end = end_raw;
      end
   endgenerate
endmodule

// File: rtl/frame_sym_detector.sv
module frame_sym_detector
   import fsd_pkg::*;
#(
   parameter int SYM_BITS = 3,
   parameter bit GATE_RST = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic detect,
   output logic frame_end
);
   localparam int MIN_SW = $clog2(SYM_BITS + 1);

   generate
      if (SYM_BITS != 3) begin : g_bad_len
         $error("frame_sym_detector supports only three-bit symbols");
      end
      if (FSD_SW < MIN_SW) begin : g_bad_sw
         $error("frame_sym_detector state register too narrow");
      end
   endgenerate

   fsd_state_t cur, nxt;

   fsd_next u_next (
      .cur    (cur),
      .bit_in (bit_in),
      .nxt    (nxt)
   );

   fsd_state_reg u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .cur (cur)
   );

   fsd_out #(.GATE_RST(GATE_RST)) u_out (
      .rst       (rst),
      .cur       (cur),
      .bit_in    (bit_in),
      .detect    (detect),
      .frame_end (frame_end)
   );
endmodule

// File: rtl/frame_sym_detector_chk.sv
module frame_sym_detector_chk (
   input logic clk,
   input logic rst,
   input logic bit_in,
   input logic detect,
   input logic frame_end
);
   AST_RST_QUIET: assert property (@(posedge clk) rst |-> (!detect && !frame_end)); // R1
   AST_RST_RESTART: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !frame_end); // R1
   AST_END_SPACING: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> !frame_end ##1 !frame_end ##1 frame_end); // R2
   AST_DET_LAST_ONLY: assert property (@(posedge clk) disable iff (rst) detect |-> frame_end); // R5
   AST_DET_ZERO_BIT: assert property (@(posedge clk) disable iff (rst) detect |-> !bit_in); // R3
   AST_DET_PREV_ONE: assert property (@(posedge clk) disable iff (rst) detect |-> $past(bit_in)); // R3
endmodule

bind frame_sym_detector frame_sym_detector_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .bit_in    (bit_in),
   .detect    (detect),
   .frame_end (frame_end)
);

// File: tb/frame_sym_detector_bench.sv
`timescale 1ns/1ps
module frame_sym_detector_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic detect, frame_end;

   int n_tests = 0;
   int n_fail = 0;
   int pos = 0;
   logic prev = 1'b0;

   always #5 clk = ~clk;

   frame_sym_detector u_frame_sym_detector (
      .clk       (clk),
      .rst       (rst),
      .bit_in    (bit_in),
      .detect    (detect),
      .frame_end (frame_end)
   );

   function automatic logic exp_det(input logic r, input int p, input logic pv, input logic b);
      return !r && (p == 2) && pv && !b;
   endfunction

   function automatic logic exp_end(input logic r, input int p);
      return !r && (p == 2);
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // Drive one bit after the falling edge, check both outputs in the same cycle, then let the edge consume it.
   task automatic step(input logic r, input logic b, input string req);
      @(negedge clk);
      rst = r;
      bit_in = b;
      #2;
      check({req, " detect"}, detect, exp_det(r, pos, prev, b));
      check({req, " frame_end"}, frame_end, exp_end(r, pos));
      @(posedge clk);
      if (r) pos = 0;
      else pos = (pos + 1) % 3;
      prev = b;
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed = 32'h1F3A;
      void'($urandom(seed));
      // R1: outputs quiet during reset, even with a 0 on the input
      step(1'b1, 1'b0, "R1");
      step(1'b1, 1'b1, "R1");
      // R3 R4 R5: every three-bit code, first bit both ways
      for (int c = 0; c < 8; c++) begin
         step(1'b0, c[2], "R4");
         step(1'b0, c[1], "R5");
         step(1'b0, c[0], "R3");
      end
      // R7: same state, detect follows the bit within the cycle
      step(1'b0, 1'b1, "R7");
      step(1'b0, 1'b1, "R7");
      @(negedge clk);
      bit_in = 1'b1;
      #1;
      check("R7 detect with bit 1", detect, 1'b0);
      bit_in = 1'b0;
      #1;
      check("R7 detect with bit 0", detect, 1'b1);
      @(posedge clk);
      pos = 0;
      prev = 1'b0;
      // R6: a 1-then-0 pair straddling the boundary gives nothing
      step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, "R6");
      step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b0, "R6");
      step(1'b0, 1'b1, "R6");
      // R1: reset in the middle of a symbol restarts framing
      step(1'b0, 1'b1, "R1");
      step(1'b1, 1'b1, "R1");
      step(1'b0, 1'b1, "R1");
      step(1'b0, 1'b1, "R1");
      step(1'b0, 1'b0, "R1");
      // R2 R3 R5: random stream with occasional resets
      for (int i = 0; i < 600; i++) begin
         logic r = ($urandom % 40) == 0;
         step(r, 1'($urandom), "R2");
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule